// File: doc/BRIEF.md
# Interrupt and Subroutine Stack-Frame Sequencer

This block is the part of a small 8-bit processor core that moves register contents to and from a byte-wide stack in memory. The core starts one operation with a single-cycle `start` pulse and a 4-bit operation code. The block owns the 16-bit stack pointer. It makes one memory access per cycle, on an interface whose read data must be valid in the same cycle as the address. It pulses `done` when the operation finishes. The operations are: software interrupt, wait-for-interrupt, return from interrupt, subroutine call, return from subroutine, and single-byte push and pull of either accumulator.

The core's accumulators A and B, its index register X, its program counter and its status byte are captured when an operation starts. The block drives values restored from the stack, or fetched from an interrupt vector, on separate output ports, and these hold until the next operation rewrites them. The stack pointer always addresses the next free byte. The full interrupt frame is seven bytes. Wait-for-interrupt stacks that frame ahead of time and then stalls. When a wake-up arrives, the block fetches only the vector, because the frame is already on the stack.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset the stack pointer equals the parameter `SP_INIT`. `done` and `stalled` are low, and no memory read or write is issued.
- R2: Software interrupt (code 0) writes seven bytes. The program counter low byte goes at SP, the program counter high byte at SP-1, X low at SP-2, X high at SP-3, A at SP-4, B at SP-5 and the status byte at SP-6. SP then drops by 7.
- R3: Software interrupt then reads the new program counter, high byte from 0xFFFA and low byte from 0xFFFB. It drives the captured status byte with bit 4 (the interrupt mask) set. It takes 12 cycles from start to done, with 7 writes and 2 reads.
- R4: Return from interrupt (code 2) reads the status byte from SP+1, B from SP+2, A from SP+3, X high from SP+4, X low from SP+5, PC high from SP+6 and PC low from SP+7. SP then rises by 7. It takes 10 cycles.
- R5: Wait-for-interrupt (code 1) writes the same frame as R2 and lowers SP by 7 in 9 cycles. After that, `stalled` stays high, with no memory access and no change of SP, until a wake-up is accepted.
- R6: While stalled, `nmi_wake` is always accepted and fetches the vector at 0xFFFC/0xFFFD. `irq_wake` is accepted only if bit 4 of the captured status byte is clear, and fetches 0xFFF8/0xFFF9. If both are high, `nmi_wake` wins. `done` follows 2 cycles after the wake is sampled, and the status output has bit 4 set.
- R7: Subroutine call (code 3) writes PC low at SP and PC high at SP-1. SP then drops by 2. It takes 8 cycles.
- R8: Return from subroutine (code 4) reads PC high from SP+1 and PC low from SP+2. SP then rises by 2. It takes 5 cycles.
- R9: Push of A (code 5) or B (code 6) writes the accumulator at SP and then decrements SP. Pull into A (code 7) or B (code 8) first increments SP and then reads the byte at the new SP. Each takes 4 cycles, and a series of pushes and pulls behaves last-in first-out.
- R10: No cycle carries both a read and a write.
- R11: `done` is high for exactly one cycle, the last cycle of the operation. A `start` pulse while an operation is running or stalled is ignored.
- R12: An unassigned operation code (9 to 15) finishes in 1 cycle with no memory access and no change of SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator A from the core |
| b_i | input | 8 | Accumulator B from the core |
| x_i | input | 16 | Index register from the core |
| pc_i | input | 16 | Program counter to stack |
| sr_i | input | 8 | Status byte from the core |
| nmi_wake | input | 1 | Non-maskable wake-up |
| irq_wake | input | 1 | Maskable wake-up |
| mem_rdata | input | 8 | Read data, valid in the address cycle |
| mem_addr | output | 16 | Memory byte address |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| sp_o | output | 16 | Stack pointer |
| a_o | output | 8 | Restored accumulator A |
| b_o | output | 8 | Restored accumulator B |
| x_o | output | 16 | Restored index register |
| pc_o | output | 16 | Restored or vector program counter |
| sr_o | output | 8 | Restored or masked status byte |
| done | output | 1 | One-cycle completion pulse |
| stalled | output | 1 | Frame stacked, waiting for wake-up |

## Verification
Two pairs of events can land in the same cycle. The first pair is a new `start` that arrives in the middle of a software interrupt. The bench raises `start` with a push code partway through the sequence. It then judges that the write count, the final stack pointer and the single `done` pulse match a lone software interrupt. The second pair is both wake inputs rising in the same cycle while the block is stalled with the mask set. The bench expects the non-maskable vector at 0xFFFC/0xFFFD, after first showing that the maskable wake-up alone leaves the block stalled.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int ADDR_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int STEP_W      = 4;
    localparam int FRAME_BYTES = 7;
    localparam int VEC_CYC     = 2;
    localparam int SWI_LEN     = 12;
    localparam int WAI_LEN     = 9;
    localparam int RTI_LEN     = 10;
    localparam int CALL_LEN    = 8;
    localparam int RTS_LEN     = 5;
    localparam int PP_LEN      = 4;
    localparam int SWI_VEC_AT  = SWI_LEN - VEC_CYC - 1;
    localparam int WAI_HOLD_AT = WAI_LEN - 1;
    localparam int LAST_FRAME  = FRAME_BYTES - 1;

    typedef enum logic [3:0] {
        OP_SWI  = 4'd0, OP_WAI  = 4'd1, OP_RTI  = 4'd2,
        OP_CALL = 4'd3, OP_RTS  = 4'd4, OP_PSHA = 4'd5,
        OP_PSHB = 4'd6, OP_PULA = 4'd7, OP_PULB = 4'd8
    } op_e;

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_WAIT, PH_VEC} phase_e;
    typedef enum logic [1:0] {ACC_NONE, ACC_WR, ACC_RD} acc_e;
    typedef enum logic [2:0] {
        F_PCL = 3'd0, F_PCH = 3'd1, F_XL = 3'd2, F_XH = 3'd3,
        F_A = 3'd4, F_B = 3'd5, F_SR = 3'd6
    } field_e;

    typedef struct packed {
        acc_e              acc;
        field_e            fld;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        sp_step;
        logic              last;
        logic              to_vec;
        logic              to_wait;
    } step_act_t;
endpackage

// File: rtl/sfs_wake_qual.sv
module sfs_wake_qual #(
    parameter int          MASK_BIT = 4,
    parameter logic [15:0] VEC_NMI  = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ  = 16'hFFF8
) (
    input  logic        nmi_i,
    input  logic        irq_i,
    input  logic [7:0]  sr_i,
    output logic        wake_o,
    output logic [15:0] vec_o
);
    always_comb begin
        wake_o = nmi_i | (irq_i & ~sr_i[MASK_BIT]);
        vec_o  = nmi_i ? VEC_NMI : VEC_IRQ;
    end
endmodule

// File: rtl/sfs_step_decode.sv
module sfs_step_decode
    import sfs_pkg::*;
(
    input  phase_e                  phase_i,
    input  op_e                     op_i,
    input  logic [STEP_W-1:0]       step_i,
    input  logic [ADDR_W-1:0]       sp_i,
    input  logic [ADDR_W-1:0]       vec_i,
    output step_act_t               act_o
);
    logic [ADDR_W-1:0] below, above;

    always_comb begin
        below = sp_i - ADDR_W'(step_i);
        above = sp_i + ADDR_W'(step_i) + ADDR_W'(1);
        act_o = '0;
        act_o.acc  = ACC_NONE;
        act_o.fld  = F_PCL;
        act_o.addr = sp_i;
        if (phase_i == PH_VEC) begin
            act_o.acc  = ACC_RD;
            act_o.addr = vec_i + ADDR_W'(step_i[0]);
            act_o.fld  = step_i[0] ? F_PCL : F_PCH;
            act_o.last = step_i[0];
        end else if (phase_i == PH_RUN) begin
            case (op_i)
                OP_SWI, OP_WAI: begin
                    if (step_i <= STEP_W'(LAST_FRAME)) begin
                        act_o.acc  = ACC_WR;
                        act_o.addr = below;
                        act_o.fld  = field_e'(step_i[2:0]);
                    end
                    if (step_i == STEP_W'(LAST_FRAME)) act_o.sp_step = 4'h9;
                    if (op_i == OP_SWI && step_i == STEP_W'(SWI_VEC_AT)) act_o.to_vec = 1'b1;
                    if (op_i == OP_WAI && step_i == STEP_W'(WAI_HOLD_AT)) act_o.to_wait = 1'b1;
                end
                OP_RTI: begin
                    if (step_i <= STEP_W'(LAST_FRAME)) begin
                        act_o.acc  = ACC_RD;
                        act_o.addr = above;
                        act_o.fld  = field_e'(3'd6 - step_i[2:0]);
                    end
                    if (step_i == STEP_W'(LAST_FRAME)) act_o.sp_step = 4'h7;
                    act_o.last = (step_i == STEP_W'(RTI_LEN - 1));
                end
                OP_CALL: begin
                    if (step_i <= STEP_W'(1)) begin
                        act_o.acc  = ACC_WR;
                        act_o.addr = below;
                        act_o.fld  = step_i[0] ? F_PCH : F_PCL;
                    end
                    if (step_i == STEP_W'(1)) act_o.sp_step = 4'hE;
                    act_o.last = (step_i == STEP_W'(CALL_LEN - 1));
                end
                OP_RTS: begin
                    if (step_i <= STEP_W'(1)) begin
                        act_o.acc  = ACC_RD;
                        act_o.addr = above;
                        act_o.fld  = step_i[0] ? F_PCL : F_PCH;
                    end
                    if (step_i == STEP_W'(1)) act_o.sp_step = 4'h2;
                    act_o.last = (step_i == STEP_W'(RTS_LEN - 1));
                end
                OP_PSHA, OP_PSHB: begin
                    if (step_i == '0) begin
                        act_o.acc     = ACC_WR;
                        act_o.sp_step = 4'hF;
                    end
                    act_o.fld  = (op_i == OP_PSHA) ? F_A : F_B;
                    act_o.last = (step_i == STEP_W'(PP_LEN - 1));
                end
                OP_PULA, OP_PULB: begin
                    if (step_i == '0) act_o.sp_step = 4'h1;
                    if (step_i == STEP_W'(1)) act_o.acc = ACC_RD;
                    act_o.fld  = (op_i == OP_PULA) ? F_A : F_B;
                    act_o.last = (step_i == STEP_W'(PP_LEN - 1));
                end
                default: act_o.last = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
    import sfs_pkg::*;
#(
    parameter logic [15:0] SP_INIT  = 16'h00E0,
    parameter int          MASK_BIT = 4,
    parameter logic [15:0] VEC_SWI  = 16'hFFFA,
    parameter logic [15:0] VEC_NMI  = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ  = 16'hFFF8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [3:0]  op_i,
    input  logic [7:0]  a_i,
    input  logic [7:0]  b_i,
    input  logic [15:0] x_i,
    input  logic [15:0] pc_i,
    input  logic [7:0]  sr_i,
    input  logic        nmi_wake,
    input  logic        irq_wake,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic        mem_wr,
    output logic        mem_rd,
    output logic [7:0]  mem_wdata,
    output logic [15:0] sp_o,
    output logic [7:0]  a_o,
    output logic [7:0]  b_o,
    output logic [15:0] x_o,
    output logic [15:0] pc_o,
    output logic [7:0]  sr_o,
    output logic        done,
    output logic        stalled
);
    localparam logic [7:0] MASK_SET = 8'(1) << MASK_BIT;

    typedef struct packed {
        phase_e              phase;
        op_e                 op;
        logic [STEP_W-1:0]   step;
        logic [ADDR_W-1:0]   sp;
        logic [ADDR_W-1:0]   vec;
        logic [BYTE_W-1:0]   sa, sb, ssr;
        logic [ADDR_W-1:0]   sx, spc;
        logic [BYTE_W-1:0]   ra, rb, rsr;
        logic [ADDR_W-1:0]   rx, rpc;
    } state_t;

    state_t    q, d;
    step_act_t act;
    logic      wake;
    logic [ADDR_W-1:0] wake_vec;

    sfs_step_decode u_dec (
        .phase_i (q.phase),
        .op_i    (q.op),
        .step_i  (q.step),
        .sp_i    (q.sp),
        .vec_i   (q.vec),
        .act_o   (act)
    );

    sfs_wake_qual #(.MASK_BIT(MASK_BIT), .VEC_NMI(VEC_NMI), .VEC_IRQ(VEC_IRQ)) u_wake (
        .nmi_i  (nmi_wake),
        .irq_i  (irq_wake),
        .sr_i   (q.ssr),
        .wake_o (wake),
        .vec_o  (wake_vec)
    );

    logic active;
    assign active = (q.phase == PH_RUN) || (q.phase == PH_VEC);

    always_comb begin
        d         = q;
        mem_addr  = act.addr;
        mem_wr    = active && (act.acc == ACC_WR);
        mem_rd    = active && (act.acc == ACC_RD);
        done      = active && act.last;
        stalled   = (q.phase == PH_WAIT);
        case (act.fld)
            F_PCL:   mem_wdata = q.spc[7:0];
            F_PCH:   mem_wdata = q.spc[15:8];
            F_XL:    mem_wdata = q.sx[7:0];
            F_XH:    mem_wdata = q.sx[15:8];
            F_A:     mem_wdata = q.sa;
            F_B:     mem_wdata = q.sb;
            default: mem_wdata = q.ssr;
        endcase

        case (q.phase)
            PH_IDLE: if (start) begin
                d.phase = PH_RUN;
                d.op    = op_e'(op_i);
                d.step  = '0;
                d.sa    = a_i;
                d.sb    = b_i;
                d.sx    = x_i;
                d.spc   = pc_i;
                d.ssr   = sr_i;
            end
            PH_WAIT: if (wake) begin
                d.phase = PH_VEC;
                d.step  = '0;
                d.vec   = wake_vec;
                d.rsr   = q.ssr | MASK_SET;
            end
            default: begin
                if (mem_rd) begin
                    case (act.fld)
                        F_PCL:   d.rpc[7:0]  = mem_rdata;
                        F_PCH:   d.rpc[15:8] = mem_rdata;
                        F_XL:    d.rx[7:0]   = mem_rdata;
                        F_XH:    d.rx[15:8]  = mem_rdata;
                        F_A:     d.ra        = mem_rdata;
                        F_B:     d.rb        = mem_rdata;
                        default: d.rsr       = mem_rdata;
                    endcase
                end
                d.sp = q.sp + {{(ADDR_W-4){act.sp_step[3]}}, act.sp_step};
                if (act.last) begin
                    d.phase = PH_IDLE;
                end else if (act.to_vec) begin
                    d.phase = PH_VEC;
                    d.step  = '0;
                    d.vec   = VEC_SWI;
                    d.rsr   = q.ssr | MASK_SET;
                end else if (act.to_wait) begin
                    d.phase = PH_WAIT;
                end else begin
                    d.step = q.step + STEP_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.op    <= OP_SWI;
            q.sp    <= SP_INIT;
        end else begin
            q <= d;
        end
    end

    assign sp_o = q.sp;
    assign a_o  = q.ra;
    assign b_o  = q.rb;
    assign x_o  = q.rx;
    assign pc_o = q.rpc;
    assign sr_o = q.rsr;

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE) |-> (!mem_wr && !mem_rd && !done)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_IDLE_SP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE) |=> $stable(q.sp)); // R12
    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> (!mem_wr && !mem_rd)); // R5
    AST_WAIT_SP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |=> $stable(q.sp)); // R5
    AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && irq_wake && !nmi_wake && q.ssr[MASK_BIT]) |=> stalled); // R6
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done) |=> $stable(q.op)); // R11
endmodule

// File: tb/tb_stack_frame_seq.sv
module tb_stack_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  a_i = '0, b_i = '0, sr_i = '0;
    logic [15:0] x_i = '0, pc_i = '0;
    logic        nmi_wake = 1'b0, irq_wake = 1'b0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, sp_o, x_o, pc_o;
    logic        mem_wr, mem_rd, done, stalled;
    logic [7:0]  mem_wdata, a_o, b_o, sr_o;

    logic [7:0]  mem [256];
    logic        pre_we = 1'b0;
    logic [7:0]  pre_addr = '0, pre_data = '0;
    int          checks = 0, failures = 0, wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
    int          cyc;
    bit          finished = 1'b0;

    stack_frame_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .x_i(x_i), .pc_i(pc_i), .sr_i(sr_i),
        .nmi_wake(nmi_wake), .irq_wake(irq_wake), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
        .sp_o(sp_o), .a_o(a_o), .b_o(b_o), .x_o(x_o), .pc_o(pc_o), .sr_o(sr_o),
        .done(done), .stalled(stalled)
    );

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        else if (pre_we) mem[pre_addr] <= pre_data;
        if (mem_wr) wr_cnt <= wr_cnt + 1;
        if (mem_rd) rd_cnt <= rd_cnt + 1;
        if (mem_wr && mem_rd) both_cnt <= both_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic preload(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = addr; pre_data = data;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    // Issues an operation; poke >= 1 raises start with a push code in that cycle.
    task automatic run_op(input logic [3:0] code, input int poke);
        @(negedge clk);
        wr_cnt = 0; rd_cnt = 0;
        op_i = code; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cyc = 1;
        while (!done && !stalled && cyc < 100) begin
            if (cyc == poke) begin start = 1'b1; op_i = 4'd5; end
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
    endtask

    task automatic wake(input logic nmi, input logic irq);
        nmi_wake = nmi; irq_wake = irq;
        @(negedge clk);
        nmi_wake = 1'b0; irq_wake = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic frame_check(input string req, input logic [7:0] top);
        check(req, {24'h0, mem[top]},     {24'h0, pc_i[7:0]});
        check(req, {24'h0, mem[top - 1]}, {24'h0, pc_i[15:8]});
        check(req, {24'h0, mem[top - 2]}, {24'h0, x_i[7:0]});
        check(req, {24'h0, mem[top - 3]}, {24'h0, x_i[15:8]});
        check(req, {24'h0, mem[top - 4]}, {24'h0, a_i});
        check(req, {24'h0, mem[top - 5]}, {24'h0, b_i});
        check(req, {24'h0, mem[top - 6]}, {24'h0, sr_i});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sp", {16'h0, sp_o}, 32'h00E0);
        check("R1 done", {31'h0, done}, 0);
        check("R1 stalled", {31'h0, stalled}, 0);
        check("R1 access", {30'h0, mem_wr, mem_rd}, 0);

        preload(8'hF8, 8'hAB); preload(8'hF9, 8'hCD);
        preload(8'hFA, 8'h12); preload(8'hFB, 8'h34);
        preload(8'hFC, 8'h9E); preload(8'hFD, 8'h0F);

        // R9 push sweep then pull back in reverse order
        for (int i = 0; i < 6; i++) begin
            a_i = 8'(i * 37 + 5); b_i = 8'(i * 11 + 200);
            run_op((i % 2 == 0) ? 4'd5 : 4'd6, -1);
            check("R9 push cycles", cyc, 4);
            @(negedge clk);
            check("R9 push sp", {16'h0, sp_o}, 32'(16'h00E0 - 16'(i + 1)));
            check("R9 push byte", {24'h0, mem[8'(8'hE0 - i)]},
                  {24'h0, (i % 2 == 0) ? a_i : b_i});
            check("R10 push writes", wr_cnt, 1);
        end
        for (int i = 5; i >= 0; i--) begin
            run_op((i % 2 == 0) ? 4'd7 : 4'd8, -1);
            check("R9 pull cycles", cyc, 4);
            @(negedge clk);
            check("R9 pull sp", {16'h0, sp_o}, 32'(16'h00E0 - 16'(i)));
            check("R9 pull value", {24'h0, (i % 2 == 0) ? a_o : b_o},
                  {24'h0, (i % 2 == 0) ? 8'(i * 37 + 5) : 8'(i * 11 + 200)});
        end

        // R7 call, R8 return from subroutine
        pc_i = 16'h5566;
        run_op(4'd3, -1);
        check("R7 cycles", cyc, 8);
        @(negedge clk);
        check("R7 sp", {16'h0, sp_o}, 32'h00DE);
        check("R7 low byte", {24'h0, mem[8'hE0]}, 32'h66);
        check("R7 high byte", {24'h0, mem[8'hDF]}, 32'h55);
        pc_i = 16'h0000;
        run_op(4'd4, -1);
        check("R8 cycles", cyc, 5);
        @(negedge clk);
        check("R8 pc", {16'h0, pc_o}, 32'h5566);
        check("R8 sp", {16'h0, sp_o}, 32'h00E0);

        // R2 R3 software interrupt, with an ignored start in cycle 4 (R11)
        a_i = 8'h11; b_i = 8'h22; x_i = 16'h3344; pc_i = 16'h5566; sr_i = 8'hC0;
        run_op(4'd0, 4);
        check("R3 cycles", cyc, 12);
        @(negedge clk);
        check("R11 done one cycle", {31'h0, done}, 0);
        check("R2 sp", {16'h0, sp_o}, 32'h00D9);
        frame_check("R2 frame", 8'hE0);
        check("R3 writes", wr_cnt, 7);
        check("R3 reads", rd_cnt, 2);
        check("R3 vector", {16'h0, pc_o}, 32'h1234);
        check("R3 mask set", {24'h0, sr_o}, 32'hD0);
        repeat (4) @(negedge clk);
        check("R11 ignored start sp", {16'h0, sp_o}, 32'h00D9);
        check("R11 ignored start quiet", {30'h0, done, mem_wr}, 0);

        // R4 return from interrupt
        a_i = 8'h00; b_i = 8'h00; x_i = 16'h0; pc_i = 16'h0; sr_i = 8'h00;
        run_op(4'd2, -1);
        check("R4 cycles", cyc, 10);
        @(negedge clk);
        check("R4 sp", {16'h0, sp_o}, 32'h00E0);
        check("R4 sr", {24'h0, sr_o}, 32'hC0);
        check("R4 b", {24'h0, b_o}, 32'h22);
        check("R4 a", {24'h0, a_o}, 32'h11);
        check("R4 x", {16'h0, x_o}, 32'h3344);
        check("R4 pc", {16'h0, pc_o}, 32'h5566);
        check("R4 reads", rd_cnt, 7);

        // R5 R6 wait with mask clear, maskable wake
        a_i = 8'h5A; b_i = 8'hA5; x_i = 16'hBEEF; pc_i = 16'h2468; sr_i = 8'hC3;
        run_op(4'd1, -1);
        check("R5 stall after 9 cycles", cyc, 10);
        check("R5 sp", {16'h0, sp_o}, 32'h00D9);
        frame_check("R5 frame", 8'hE0);
        for (int k = 0; k < 5; k++) begin
            start = (k == 2);
            @(negedge clk);
            check("R5 stalled quiet", {29'h0, stalled, mem_wr, mem_rd}, 32'h4);
        end
        start = 1'b0;
        wake(1'b0, 1'b1);
        check("R6 irq wake cycles", cyc, 2);
        @(negedge clk);
        check("R6 irq vector", {16'h0, pc_o}, 32'hABCD);
        check("R6 mask set", {24'h0, sr_o}, 32'hD3);
        check("R6 sp", {16'h0, sp_o}, 32'h00D9);
        run_op(4'd2, -1);
        @(negedge clk);
        check("R4 restore after wait", {16'h0, x_o}, 32'hBEEF);

        // R6 wait with mask set: irq ignored, nmi and irq together take nmi
        sr_i = 8'h10;
        run_op(4'd1, -1);
        irq_wake = 1'b1;
        repeat (5) @(negedge clk);
        check("R6 masked irq stays", {30'h0, stalled, done}, 32'h2);
        nmi_wake = 1'b1;
        @(negedge clk);
        nmi_wake = 1'b0; irq_wake = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        check("R6 nmi cycles", cyc, 2);
        @(negedge clk);
        check("R6 nmi vector", {16'h0, pc_o}, 32'h9E0F);
        run_op(4'd2, -1);
        @(negedge clk);
        check("R4 sp after second wait", {16'h0, sp_o}, 32'h00E0);

        // R12 unassigned codes
        for (int c = 9; c < 16; c++) begin
            run_op(4'(c), -1);
            check("R12 cycles", cyc, 1);
            @(negedge clk);
            check("R12 no access", wr_cnt + rd_cnt, 0);
            check("R12 sp", {16'h0, sp_o}, 32'h00E0);
        end

        check("R10 never both", both_cnt, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end
endmodule